// File: doc/BRIEF.md
# SPI Serial Clock and Chip-Select Generator

This block derives the serial clock of an SPI flash controller from the system clock, and it drives the chip-select line. The clock rate is set by a programmable divider. The host picks the idle level of SCK and which clock edge captures data. An extra option moves data capture to the opposite edge, which helps at fast divider settings where the read path has little margin. Every SCK edge is also sent to the data path as a one-cycle shift strobe or sample strobe, so the shifter needs no clock of its own.

A transfer engine asks for a frame by pulsing `xfer_go` together with a bit count. In hardware chip-select mode the block lowers CS_n half an SCK period before the first edge and raises it half a period after the last edge. A two-bit chip-enable field can instead hold CS_n at a fixed level set by software. The serial clock keeps running in that case, so a frame can be split over several requests while CS_n stays low.

Top module: `spi_sck_cs_unit`

## Requirements
- R1: While reset is held and just after it, SCK is low (with `pol_idle_hi`=0), CS_n is high, `busy` is low and both strobes are low.
- R2: One half SCK period lasts `div_sel`+1 system cycles, so the SCK period is 2×(`div_sel`+1) cycles. The first SCK edge comes one half period after CS_n falls.
- R3: When no frame is running, SCK rests at the level of `pol_idle_hi`. After the last edge of a frame, SCK is back at that level.
- R4: A frame of N bits produces exactly 2N SCK edges.
- R5: Edges are numbered from 1, and odd edges are leading. With `pha_late`=0, data is sampled on leading edges and shifted on trailing edges. With `pha_late`=1 this is reversed. Each frame gives N shift strobes and N sample strobes, and the strobes are high in the cycle in which SCK takes its new level.
- R6: With `smp_opp`=1, the sample strobe moves to the other edge type, so it coincides with the shift strobe on the same N edges. No strobe fires on the other N edges.
- R7: In hardware chip-select mode, CS_n stays low for exactly (2N+1)×(`div_sel`+1) cycles per frame.
- R8: `ce_mode` bit 1 enables the manual override and bit 0 sets the manual level. Value 2 holds CS_n low, value 3 holds CS_n high, and values 0 and 1 leave CS_n to the hardware. SCK and the strobes behave the same in every mode.
- R9: A change of `div_sel` during a frame takes effect only at the next half-period boundary. The half period already running keeps its length.
- R10: `xfer_go` is ignored while a frame is running, and it is ignored when `xfer_bits` is 0.
- R11: Strobes are single-cycle pulses and occur only while `busy` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| div_sel | input | DIV_W (11) | Half-period length minus one, in system cycles |
| pol_idle_hi | input | 1 | Idle level of SCK |
| pha_late | input | 1 | 0: sample on leading edges; 1: sample on trailing edges |
| smp_opp | input | 1 | Move sampling to the opposite edge type |
| ce_mode | input | 2 | Chip-select control: bit 1 enables the override, bit 0 sets the level |
| xfer_go | input | 1 | One-cycle frame request |
| xfer_bits | input | LEN_W (8) | Number of bits in the requested frame |
| sck | output | 1 | Serial clock |
| cs_n | output | 1 | Active-low chip select |
| busy | output | 1 | A frame is running |
| shift_stb | output | 1 | Data path must present the next bit |
| sample_stb | output | 1 | Data path must capture the incoming bit |

## Verification
The shift strobe and the sample strobe can fall in the same cycle. This happens only when opposite-edge sampling is on, because both strobes then land on the same SCK edge. The test runs frames with `smp_opp` set under both phase settings. It counts the cycles in which both strobes are high and expects N such cycles, and it expects zero such cycles when `smp_opp` is clear. It also checks the strobe pattern on the first edge.

// File: rtl/spi_sck_pkg.sv
package spi_sck_pkg;
   typedef enum logic [1:0] {
      SQ_IDLE = 2'd0,
      SQ_LEAD = 2'd1,
      SQ_RUN  = 2'd2
   } seq_st_e;
endpackage

// File: rtl/sck_half_timer.sv
module sck_half_timer #(
   parameter int DIV_W = 11
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             run,
   input  logic [DIV_W-1:0] div_in,
   output logic             tick
);
   logic [DIV_W-1:0] cnt_q;

   assign tick = run && (cnt_q == '0);

   // preload while idle; reload from the live divider only at a boundary
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)           cnt_q <= '0;
      else if (!run || tick) cnt_q <= div_in;
      else                  cnt_q <= cnt_q - 1'b1;
   end

   // R9
   reload_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (run && !tick && $past(run)) |=> (cnt_q == $past(cnt_q) - 1'b1));
endmodule

// File: rtl/sck_edge_seq.sv
module sck_edge_seq
   import spi_sck_pkg::*;
#(
   parameter int LEN_W = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             go,
   input  logic [LEN_W-1:0] nbits,
   input  logic             tick,
   input  logic             pha_late,
   input  logic             smp_opp,
   output logic             run,
   output logic             ph,
   output logic             hw_cs_n,
   output logic             shift_stb,
   output logic             sample_stb
);
   localparam int CW = LEN_W + 1;

   seq_st_e         st_q;
   logic [CW-1:0]   ecnt_q;
   logic [CW-1:0]   tgt_q;
   logic [CW-1:0]   nxt;
   logic            toggle;
   logic            nat_smp;

   assign run     = (st_q != SQ_IDLE);
   assign nxt     = ecnt_q + 1'b1;
   assign toggle  = tick && run && (ecnt_q != tgt_q);
   assign nat_smp = nxt[0] ^ pha_late;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_q       <= SQ_IDLE;
         ecnt_q     <= '0;
         tgt_q      <= '0;
         ph         <= 1'b0;
         hw_cs_n    <= 1'b1;
         shift_stb  <= 1'b0;
         sample_stb <= 1'b0;
      end else begin
         shift_stb  <= 1'b0;
         sample_stb <= 1'b0;
         if (st_q == SQ_IDLE) begin
            if (go && (nbits != '0)) begin
               st_q    <= SQ_LEAD;
               tgt_q   <= {nbits, 1'b0};
               ecnt_q  <= '0;
               hw_cs_n <= 1'b0;
            end
         end else if (toggle) begin
            st_q       <= SQ_RUN;
            ph         <= ~ph;
            ecnt_q     <= nxt;
            shift_stb  <= ~nat_smp;
            sample_stb <= nat_smp ^ smp_opp;
         end else if (tick) begin
            st_q    <= SQ_IDLE;
            hw_cs_n <= 1'b1;
         end
      end
   end

   // R4
   edge_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ecnt_q <= tgt_q);
   // R11
   strobe_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (shift_stb || sample_stb) |-> run);
   // R6
   coincide_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (shift_stb && sample_stb) |-> $past(smp_opp));
   // R3
   idle_level_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !run |-> !ph);
   // R5
   single_role_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ((shift_stb || sample_stb) && !$past(smp_opp)) |-> $onehot({shift_stb, sample_stb}));
endmodule

// File: rtl/spi_sck_cs_unit.sv
module spi_sck_cs_unit #(
   parameter int DIV_W  = 11,
   parameter int LEN_W  = 8,
   parameter bit CS_REG = 1'b0
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [DIV_W-1:0] div_sel,
   input  logic             pol_idle_hi,
   input  logic             pha_late,
   input  logic             smp_opp,
   input  logic [1:0]       ce_mode,
   input  logic             xfer_go,
   input  logic [LEN_W-1:0] xfer_bits,
   output logic             sck,
   output logic             cs_n,
   output logic             busy,
   output logic             shift_stb,
   output logic             sample_stb
);
   generate
      if (DIV_W < 1 || DIV_W > 16) begin : g_bad_div
         $error("DIV_W must lie in 1..16");
      end
      if (LEN_W < 1 || LEN_W > 16) begin : g_bad_len
         $error("LEN_W must lie in 1..16");
      end
   endgenerate

   logic run, tick, ph, hw_cs_n, cs_sel;

   sck_half_timer #(.DIV_W(DIV_W)) u_tmr (
      .clk(clk), .rst_n(rst_n), .run(run), .div_in(div_sel), .tick(tick)
   );

   sck_edge_seq #(.LEN_W(LEN_W)) u_seq (
      .clk(clk), .rst_n(rst_n), .go(xfer_go), .nbits(xfer_bits), .tick(tick),
      .pha_late(pha_late), .smp_opp(smp_opp), .run(run), .ph(ph),
      .hw_cs_n(hw_cs_n), .shift_stb(shift_stb), .sample_stb(sample_stb)
   );

   assign sck    = ph ^ pol_idle_hi;
   assign busy   = run;
   assign cs_sel = ce_mode[1] ? ce_mode[0] : hw_cs_n;

   generate
      if (CS_REG) begin : g_cs_reg
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) cs_n <= 1'b1;
            else        cs_n <= cs_sel;
         end
      end else begin : g_cs_comb
         assign cs_n = cs_sel;
      end
   endgenerate

   // R7
   hw_cs_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && !ce_mode[1] && !CS_REG) |-> !cs_n);
   // R3
   sck_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !busy |-> (sck == pol_idle_hi));
endmodule

// File: tb/sim_spi_sck_cs_unit.sv
module sim_spi_sck_cs_unit;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [10:0] div_sel = '0;
   logic        pol_idle_hi = 1'b0, pha_late = 1'b0, smp_opp = 1'b0;
   logic [1:0]  ce_mode = 2'd0;
   logic        xfer_go = 1'b0;
   logic [7:0]  xfer_bits = '0;
   logic        sck, cs_n, busy, shift_stb, sample_stb;
   int          errors = 0, checks = 0;

   always #10 clk = ~clk;

   spi_sck_cs_unit u0 (
      .clk(clk), .rst_n(rst_n), .div_sel(div_sel), .pol_idle_hi(pol_idle_hi),
      .pha_late(pha_late), .smp_opp(smp_opp), .ce_mode(ce_mode),
      .xfer_go(xfer_go), .xfer_bits(xfer_bits), .sck(sck), .cs_n(cs_n),
      .busy(busy), .shift_stb(shift_stb), .sample_stb(sample_stb)
   );

   // entry: div[18:11] pol[10] pha[9] opp[8] bits[7:0]
   localparam int NV = 7;
   localparam logic [18:0] VEC [NV] = '{
      {8'd0, 1'b0, 1'b0, 1'b0, 8'd1},
      {8'd1, 1'b0, 1'b1, 1'b0, 8'd3},
      {8'd3, 1'b1, 1'b0, 1'b0, 8'd2},
      {8'd2, 1'b1, 1'b1, 1'b0, 8'd4},
      {8'd0, 1'b0, 1'b0, 1'b1, 8'd5},
      {8'd1, 1'b1, 1'b1, 1'b1, 8'd2},
      {8'd5, 1'b0, 1'b0, 1'b0, 8'd1}
   };

   task automatic chk(input string req, input int act, input int exp);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   int m_low, m_first, m_tog, m_shf, m_smp, m_both, m_pat, m_gap_err;
   bit m_end_sck;

   task automatic run_xfer(input int d, input bit pl, input bit pa, input bit op,
                           input int n, input int gap, input int kick_at,
                           input int ndiv_at, input int ndiv);
      int  c = 1, last = -1;
      bit  prev;
      @(negedge clk);
      div_sel = 11'(d); pol_idle_hi = pl; pha_late = pa; smp_opp = op;
      xfer_bits = 8'(n); xfer_go = 1'b1;
      prev = pl;
      m_low = 0; m_first = -1; m_tog = 0; m_shf = 0; m_smp = 0; m_both = 0;
      m_pat = -1; m_gap_err = 0;
      @(negedge clk);
      xfer_go = 1'b0;
      while (c < 5000) begin
         if (!cs_n) m_low++;
         if (sck != prev) begin
            m_tog++;
            if (m_first < 0) begin m_first = c; m_pat = {shift_stb, sample_stb}; end
            if (last >= 0 && gap > 0 && (c - last) != gap) m_gap_err++;
            last = c;
         end
         prev = sck;
         if (shift_stb) m_shf++;
         if (sample_stb) m_smp++;
         if (shift_stb && sample_stb) m_both++;
         if (c > 1 && !busy) break;
         if (c == kick_at) begin xfer_go = 1'b1; xfer_bits = 8'd7; end
         else xfer_go = 1'b0;
         if (c == ndiv_at) div_sel = 11'(ndiv);
         @(negedge clk);
         c++;
      end
      xfer_go = 1'b0;
      m_end_sck = sck;
   endtask

   initial begin : watchdog
      repeat (150000) @(posedge clk);
      errors++; checks++;
      $display("FAIL watchdog actual=1 expected=0");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      // R1 reset state
      chk("R1 sck", sck, 0); chk("R1 cs_n", cs_n, 1); chk("R1 busy", busy, 0);
      chk("R1 strobes", shift_stb | sample_stb, 0);
      rst_n = 1'b1;
      @(negedge clk);
      chk("R1 after release cs_n", cs_n, 1);

      for (int i = 0; i < NV; i++) begin
         int d, n, h; bit pl, pa, op;
         d = VEC[i][18:11]; pl = VEC[i][10]; pa = VEC[i][9]; op = VEC[i][8];
         n = VEC[i][7:0]; h = d + 1;
         run_xfer(d, pl, pa, op, n, h, -1, -1, 0);
         chk("R2 first edge", m_first, h + 1);
         chk("R2 half period", m_gap_err, 0);
         chk("R4 edges", m_tog, 2 * n);
         chk("R5 shifts", m_shf, n);
         chk("R5 samples", m_smp, n);
         chk("R5 first edge roles", m_pat, {pa, ~pa ^ op});
         chk("R6 coincident strobes", m_both, op ? n : 0);
         chk("R7 cs low cycles", m_low, (2 * n + 1) * h);
         chk("R3 end level", m_end_sck, pl);
      end

      // R3 idle level follows polarity
      @(negedge clk); pol_idle_hi = 1'b1; #1 chk("R3 idle high", sck, 1);
      pol_idle_hi = 1'b0; #1 chk("R3 idle low", sck, 0);

      // R8 manual chip select
      @(negedge clk); ce_mode = 2'd2; #1 chk("R8 hold low", cs_n, 0);
      ce_mode = 2'd3; #1 chk("R8 hold high", cs_n, 1);
      ce_mode = 2'd1; #1 chk("R8 code 1 is hardware", cs_n, 1);
      ce_mode = 2'd3;
      run_xfer(1, 0, 0, 0, 2, 2, -1, -1, 0);
      chk("R8 cs held high in frame", m_low, 0);
      chk("R8 clock still runs", m_tog, 4);
      ce_mode = 2'd2;
      run_xfer(0, 0, 0, 0, 2, 1, -1, -1, 0);
      chk("R8 cs held low after frame", cs_n, 0);
      ce_mode = 2'd0;

      // R10 zero-length request ignored
      @(negedge clk); xfer_bits = 8'd0; xfer_go = 1'b1;
      @(negedge clk); xfer_go = 1'b0;
      chk("R10 zero bits busy", busy, 0);
      chk("R10 zero bits cs_n", cs_n, 1);

      // R10 request during a frame ignored
      run_xfer(1, 0, 0, 0, 2, 2, 3, -1, 0);
      chk("R10 busy request edges", m_tog, 4);
      chk("R10 busy request cs low", m_low, 10);
      @(negedge clk); chk("R10 no restart", busy, 0);

      // R9 divider change applies at next boundary
      run_xfer(3, 0, 0, 0, 1, 0, -1, 2, 0);
      chk("R9 first edge kept", m_first, 5);
      chk("R9 cs low cycles", m_low, 6);
      chk("R9 edges", m_tog, 2);

      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end
endmodule